// File: doc/BRIEF.md
# Register-Pair Long-Word Load/Store Unit

This block carries data between a 16-entry, 32-bit data register file (held inside the block) and a word-addressed memory with a single 32-bit data port. A request names one register, one word address, a direction (load or store) and an optional long-word modifier. A plain request moves one word to or from the named register. A long-word request moves two adjacent 32-bit words to or from a register pair. The pair is the named register and its neighbour, whose index differs only in bit 0.

A long-word transfer starts in one of two ways. The first is a forced transfer: the modifier is set on an ordinary address. The unit then clears the address LSB, so the even word is tied to the named register and the odd word to the neighbour. The second is an unforced transfer: the address falls in a parameterised long-word window. There, long-word index k = addr − LW_BASE covers normal words 2k (low half, named register) and 2k+1 (high half, neighbour). The window takes precedence over the modifier.

The two memory beats run back to back, even or low first. Busy and a one-cycle done pulse report progress. A separate read port lets the surrounding datapath read any register.

Top module: `lw_pair_lsu`

## Requirements
- R1: The neighbour of register n is register n XOR 1 for every n from 0 to 15. A pair transfer touches exactly the named register and its neighbour.
- R2: With req_lw=1 and an address outside the window, the unit issues beats at (addr with bit 0 cleared) and then that address +1. A load places the even word in the named register and the odd word in the neighbour. A store sends the named register to the even word and the neighbour to the odd word.
- R3: With an address in [LW_BASE, LW_BASE+LW_SIZE), the unit issues beats at 2k and then 2k+1, where k = addr − LW_BASE, whatever the value of req_lw. The low word (2k) pairs with the named register and the high word (2k+1) with the neighbour.
- R4: With req_lw=0 and an address outside the window, the unit issues exactly one beat at addr. Only the named register can change.
- R5: A request is accepted on a clock edge where req_valid=1 and busy=0. Busy is high from the next cycle until done. Done is high for exactly one cycle: the third cycle after acceptance for a pair transfer and the second cycle after acceptance for a single transfer. Busy is low in the cycle after done.
- R6: A request presented while busy=1 is ignored. It causes no memory beat, no register change and no change to the transfer in flight.
- R7: A load changes no register before done. All registers it writes take their new value together on the clock edge that ends the done cycle.
- R8: After reset, busy, done and mem_req are 0 and every register reads zero.
- R9: Every beat of a store has mem_we=1 and every beat of a load has mem_we=0. A store changes no register. Read data is taken from mem_rdata in the cycle after the beat that requested it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_store | input | 1 | 1 = store, 0 = load |
| req_lw | input | 1 | Long-word modifier |
| req_addr | input | ADDR_W | Word address |
| req_reg | input | 4 | Named register index |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory beat valid |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Beat word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read beat |
| rd_idx | input | 4 | Datapath register read index |
| rd_data | output | 32 | Datapath register read data |

## Verification
On every cycle, the assertions check the following:
- the first beat of a pair is even and the second beat follows it at the next word;
- done lasts one cycle;
- memory stays quiet while the unit is idle;
- register writes happen only with done;
- a pair write always lands on two registers that differ in bit 0;
- a store writes no register.

Only the bench scenarios can show that the right words reach the right registers. This covers the steering difference between forced and window transfers, odd named registers (where the neighbour has the lower index), the window edges, and a junk request arriving mid-transfer that leaves everything unchanged.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BEAT0 = 2'd1,
        ST_BEAT1 = 2'd2,
        ST_FIN   = 2'd3
    } lsu_state_e;

    typedef enum logic [1:0] {
        XF_SINGLE = 2'd0,
        XF_FORCED = 2'd1,
        XF_WINDOW = 2'd2
    } xfer_kind_e;
endpackage

// File: rtl/lsu_addr_map.sv
module lsu_addr_map #(
    parameter int ADDR_W  = 12,
    parameter int LW_BASE = 'h800,
    parameter int LW_SIZE = 'h200
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               lw_mod,
    output lsu_pkg::xfer_kind_e kind,
    output logic [ADDR_W-1:0]  first_addr
);
    import lsu_pkg::*;

    localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(LW_BASE);
    localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(LW_BASE + LW_SIZE);

    logic [ADDR_W:0]   addr_ext;
    logic              in_win;
    logic [ADDR_W-1:0] lw_index;

    always_comb begin
        addr_ext = {1'b0, addr};
        in_win   = (addr_ext >= WIN_LO) && (addr_ext < WIN_HI);
        lw_index = addr - ADDR_W'(LW_BASE);
        if (in_win) begin
            kind       = XF_WINDOW;
            first_addr = ADDR_W'(lw_index << 1);
        end else if (lw_mod) begin
            kind       = XF_FORCED;
            first_addr = {addr[ADDR_W-1:1], 1'b0};
        end else begin
            kind       = XF_SINGLE;
            first_addr = addr;
        end
    end
endmodule

// File: rtl/lsu_regfile.sv
module lsu_regfile #(
    parameter int NREG   = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we0,
    input  logic [IDX_W-1:0]  widx0,
    input  logic [DATA_W-1:0] wdata0,
    input  logic              we1,
    input  logic [IDX_W-1:0]  widx1,
    input  logic [DATA_W-1:0] wdata1,
    input  logic [IDX_W-1:0]  ridx_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]  ridx_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DATA_W-1:0] reg_d;
        always_comb begin
            reg_d = regs_q[g];
            if (we0 && (widx0 == IDX_W'(g))) begin
                reg_d = wdata0;
            end else if (we1 && (widx1 == IDX_W'(g))) begin
                reg_d = wdata1;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[g] <= '0;
            else        regs_q[g] <= reg_d;
        end
    end

    assign rdata_a = regs_q[ridx_a];
    assign rdata_b = regs_q[ridx_b];
endmodule

// File: rtl/lsu_seq.sv
module lsu_seq #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_store,
    input  logic [IDX_W-1:0]    req_reg,
    input  lsu_pkg::xfer_kind_e req_kind,
    input  logic [ADDR_W-1:0]   req_first,
    output logic                busy,
    output logic                done,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [IDX_W-1:0]    rf_ridx,
    input  logic [DATA_W-1:0]   rf_rdata,
    output logic                rf_we0,
    output logic [IDX_W-1:0]    rf_widx0,
    output logic [DATA_W-1:0]   rf_wdata0,
    output logic                rf_we1,
    output logic [IDX_W-1:0]    rf_widx1,
    output logic [DATA_W-1:0]   rf_wdata1
);
    import lsu_pkg::*;

    localparam logic [IDX_W-1:0] NB_FLIP = IDX_W'(1);

    typedef struct packed {
        lsu_state_e        st;
        logic              store;
        logic              pair;
        logic [IDX_W-1:0]  named;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] lo;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d         = q;
        busy      = (q.st != ST_IDLE);
        done      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.addr;
        mem_wdata = rf_rdata;
        rf_ridx   = q.named;
        rf_we0    = 1'b0;
        rf_widx0  = q.named;
        rf_wdata0 = mem_rdata;
        rf_we1    = 1'b0;
        rf_widx1  = q.named ^ NB_FLIP;
        rf_wdata1 = mem_rdata;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_BEAT0;
                    d.store = req_store;
                    d.pair  = (req_kind != XF_SINGLE);
                    d.named = req_reg;
                    d.addr  = req_first;
                end
            end
            ST_BEAT0: begin
                mem_req = 1'b1;
                mem_we  = q.store;
                d.st    = q.pair ? ST_BEAT1 : ST_FIN;
            end
            ST_BEAT1: begin
                mem_req  = 1'b1;
                mem_we   = q.store;
                mem_addr = q.addr + ADDR_W'(1);
                rf_ridx  = q.named ^ NB_FLIP;
                d.lo     = mem_rdata;
                d.st     = ST_FIN;
            end
            ST_FIN: begin
                done = 1'b1;
                if (!q.store) begin
                    rf_we0    = 1'b1;
                    rf_wdata0 = q.pair ? q.lo : mem_rdata;
                    rf_we1    = q.pair;
                end
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_FIRST_BEAT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BEAT0 && q.pair) |-> (mem_req && !mem_addr[0])); // R2
    AST_SECOND_BEAT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_BEAT0 && q.pair) |=> (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(1))); // R3
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done)); // R6
    AST_STORE_NO_RF: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (!rf_we0 && !rf_we1)); // R9
endmodule

// File: rtl/lw_pair_lsu.sv
module lw_pair_lsu #(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int NREG    = 16,
    parameter int LW_BASE = 'h800,
    parameter int LW_SIZE = 'h200,
    localparam int IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic              req_lw,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [IDX_W-1:0]  req_reg,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    import lsu_pkg::*;

    xfer_kind_e        kind;
    logic [ADDR_W-1:0] first_addr;
    logic [IDX_W-1:0]  rf_ridx;
    logic [DATA_W-1:0] rf_rdata;
    logic              rf_we0, rf_we1;
    logic [IDX_W-1:0]  rf_widx0, rf_widx1;
    logic [DATA_W-1:0] rf_wdata0, rf_wdata1;

    lsu_addr_map #(.ADDR_W(ADDR_W), .LW_BASE(LW_BASE), .LW_SIZE(LW_SIZE)) u_map (
        .addr       (req_addr),
        .lw_mod     (req_lw),
        .kind       (kind),
        .first_addr (first_addr)
    );

    lsu_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_store (req_store),
        .req_reg   (req_reg),
        .req_kind  (kind),
        .req_first (first_addr),
        .busy      (busy),
        .done      (done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .rf_ridx   (rf_ridx),
        .rf_rdata  (rf_rdata),
        .rf_we0    (rf_we0),
        .rf_widx0  (rf_widx0),
        .rf_wdata0 (rf_wdata0),
        .rf_we1    (rf_we1),
        .rf_widx1  (rf_widx1),
        .rf_wdata1 (rf_wdata1)
    );

    lsu_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we0     (rf_we0),
        .widx0   (rf_widx0),
        .wdata0  (rf_wdata0),
        .we1     (rf_we1),
        .widx1   (rf_widx1),
        .wdata1  (rf_wdata1),
        .ridx_a  (rf_ridx),
        .rdata_a (rf_rdata),
        .ridx_b  (rd_idx),
        .rdata_b (rd_data)
    );

    AST_RF_WRITE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we0 || rf_we1) |-> done); // R7
    AST_PAIR_NEIGHBOUR: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we0 && rf_we1) |-> ((rf_widx0 ^ rf_widx1) == IDX_W'(1))); // R1
endmodule

// File: tb/tb_lw_pair_lsu.sv
`timescale 1ns/1ps
module tb_lw_pair_lsu;
    localparam int AW   = 12;
    localparam int BASE = 'h800;
    localparam int SIZE = 'h200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0, req_lw = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]  req_reg = '0;
    logic        busy, done, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;

    int n_chk = 0, n_fail = 0;
    logic [31:0] mem [0:4095];
    logic [31:0] pend = '0;
    logic [31:0] exp_rf [16];
    logic [AW-1:0] log_addr [4];
    logic        log_we [4];
    int          log_n = 0;
    int          cyc_total = 0;

    always #4 clk = ~clk;

    lw_pair_lsu dut (.*);

    always @(negedge clk) begin
        mem_rdata = pend;
        if (mem_req) begin
            if (log_n < 4) begin
                log_addr[log_n] = mem_addr;
                log_we[log_n]   = mem_we;
            end
            log_n++;
            if (mem_we) mem[mem_addr] = mem_wdata;
            else        pend = mem[mem_addr];
        end
    end

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc_total);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic bit in_win(input logic [AW-1:0] a);
        return (int'(a) >= BASE) && (int'(a) < BASE + SIZE);
    endfunction

    function automatic logic [AW-1:0] first_of(input logic [AW-1:0] a, input bit lw);
        if (in_win(a)) return AW'((int'(a) - BASE) * 2);
        if (lw)        return a & ~AW'(1);
        return a;
    endfunction

    task automatic check_all_regs(input string req);
        bit ok = 1'b1;
        logic [31:0] bad_a = '0, bad_e = '0;
        for (int i = 0; i < 16; i++) begin
            rd_idx = 4'(i);
            #1;
            if (rd_data !== exp_rf[i]) begin
                ok = 1'b0; bad_a = rd_data; bad_e = exp_rf[i];
            end
        end
        chk(ok, req, bad_a, bad_e);
    endtask

    task automatic do_op(input bit st, input bit lw, input logic [AW-1:0] a,
                         input logic [3:0] r, input bit junk);
        bit pair = in_win(a) || lw;
        logic [AW-1:0] fa = first_of(a, lw);
        logic [3:0] nb = r ^ 4'd1;
        logic [31:0] e_lo, e_hi;
        string tag = in_win(a) ? "R3" : (lw ? "R2" : "R4");
        int cyc;
        @(negedge clk);
        log_n = 0;
        e_lo = mem[fa];
        e_hi = mem[fa + AW'(1)];
        req_valid = 1'b1; req_store = st; req_lw = lw; req_addr = a; req_reg = r;
        rd_idx = r;
        @(negedge clk);
        req_valid = junk;
        if (junk) begin
            req_store = ~st; req_lw = 1'($urandom); req_addr = AW'($urandom);
            req_reg = 4'($urandom);
        end
        cyc = 1;
        rd_idx = r;
        while (!done && cyc < 8) begin
            chk(busy === 1'b1, "R5 busy during transfer", 32'(busy), 32'd1);
            if (!st) chk(rd_data === exp_rf[r], "R7 early write", rd_data, exp_rf[r]);
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        chk(cyc == (pair ? 3 : 2), "R5 done timing", 32'(cyc), pair ? 32'd3 : 32'd2);
        @(negedge clk);
        chk(!busy && !done, "R5 release", {30'd0, busy, done}, 32'd0);
        chk(log_n == (pair ? 2 : 1), junk ? "R6 beat count" : tag, 32'(log_n), pair ? 32'd2 : 32'd1);
        chk(log_addr[0] == fa, tag, 32'(log_addr[0]), 32'(fa));
        chk(log_we[0] == st, "R9 write flag", 32'(log_we[0]), 32'(st));
        if (pair && log_n >= 2)
            chk(log_addr[1] == fa + AW'(1), tag, 32'(log_addr[1]), 32'(fa + AW'(1)));
        if (st) begin
            chk(mem[fa] === exp_rf[r], tag, mem[fa], exp_rf[r]);
            if (pair) chk(mem[fa + AW'(1)] === exp_rf[nb], "R1 store neighbour", mem[fa + AW'(1)], exp_rf[nb]);
            check_all_regs("R9 store leaves registers");
        end else begin
            exp_rf[r] = e_lo;
            if (pair) exp_rf[nb] = e_hi;
            rd_idx = nb; #1;
            if (pair) chk(rd_data === e_hi, "R1 load neighbour", rd_data, e_hi);
            check_all_regs(pair ? tag : "R4 single touches named only");
        end
    endtask

    initial begin
        void'($urandom(32'h5EED1));
        for (int i = 0; i < 4096; i++) mem[i] = 32'(i) * 32'h9E3779B1 ^ 32'h5A5A0000;
        for (int i = 0; i < 16; i++) exp_rf[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req, "R8 reset outputs", {29'd0, busy, done, mem_req}, 32'd0);
        check_all_regs("R8 reset registers");

        do_op(1'b0, 1'b1, 12'h003, 4'd0, 1'b0);   // forced odd address into R0/R1
        do_op(1'b0, 1'b1, 12'h010, 4'd5, 1'b0);   // odd named register: neighbour R4
        do_op(1'b0, 1'b0, 12'h021, 4'd7, 1'b0);   // single load
        do_op(1'b0, 1'b0, 12'h800, 4'd2, 1'b0);   // window first entry, no modifier
        do_op(1'b0, 1'b1, 12'h9FF, 4'd9, 1'b0);   // window last entry with modifier
        do_op(1'b0, 1'b0, 12'hA00, 4'd11, 1'b0);  // just past window: single
        do_op(1'b0, 1'b0, 12'h7FF, 4'd12, 1'b0);  // just below window: single
        do_op(1'b1, 1'b1, 12'h101, 4'd5, 1'b1);   // forced store, junk mid-transfer
        do_op(1'b0, 1'b1, 12'h100, 4'd14, 1'b0);  // read back pair
        do_op(1'b1, 1'b0, 12'h850, 4'd1, 1'b0);   // window store
        do_op(1'b0, 1'b0, 12'h300, 4'd15, 1'b1);  // single load with junk

        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] a;
            if ($urandom % 3 == 0) a = AW'(BASE + ($urandom % SIZE));
            else                   a = AW'($urandom);
            do_op(1'($urandom), 1'($urandom), a, 4'($urandom), 1'($urandom));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule